// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block manages power for a small microcontroller. Software sets a 3-bit sleep-mode field through two write ports. The low bit of the field has its own write strobe. The other two bits share a second strobe. When the CPU issues a sleep strobe while the sleep-enable bit is set, the block moves into a low-power state. It gates a chosen set of clock enables: CPU, flash, I/O, asynchronous timer and the main oscillator.

While asleep, the block compares a vector of wake sources against a mask that belongs to the selected mode. Level-type external requests must stay active for a set number of ticks of an always-running slow clock before they are accepted. If the sleep mode stopped the oscillator, the block holds the other clocks off for a start-up delay chosen by a configuration value. It then resumes and pulses either a wake event or, when the cause was reset-class, a reset request.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset the mode field reads 000, all five enables are 1, sleeping_o is 0, and wake_o and rst_req_o are 0.
- R2: mode_hi_we_i writes mode_hi_i into mode bits [2:1]. mode_lo_we_i writes mode_lo_i into mode bit [0]. Each strobe leaves the other bits unchanged, and mode_o shows the field.
- R3: A sleep_req_i strobe puts the block to sleep at the next clock edge when sleep_en_i is 1 and the mode is a valid code. With sleep_en_i at 0, or with a reserved code (001, 100, 101), the strobe is ignored and the block stays active.
- R4: Modes 110 and 111 are entered only when xtal_src_i is 1. Otherwise the strobe is ignored.
- R5: The enables {cpu,flash,io,tmr,osc} while asleep are fixed per mode: 000 gives 00111, 010 gives 00000, 011 gives 00010, 110 gives 00001 and 111 gives 00011. When active, all five are 1.
- R6: Wake-source bits are 0 ext reset, 1 watchdog reset, 2 brown-out reset, 3 level 0, 4 level 1, 5 edge 2, 6 pin change, 7 async timer, 8 other interrupt. Mode 000 accepts all of them. Modes 010 and 110 accept bits 0 to 6. Modes 011 and 111 accept bits 0 to 7. Any other source has no effect.
- R7: Outside mode 000, a level source (bits 3 and 4) wakes the block only after LVL_HOLD consecutive slow_tick_i samples that find it active. If it drops earlier, the count clears. In mode 000 the raw level wakes the block.
- R8: When the mode stopped the oscillator (010 and 011), the clocks resume DLY_BASE << (2*startup_sel_i) cycles after the wake cycle. In every other mode they resume on the cycle after the wake condition.
- R9: Resumption gives a one-cycle wake_o pulse. For a reset-class cause (bits 0 to 2) it gives a one-cycle rst_req_o pulse instead, and the two never assert together.
- R10: The enables change only together with a state change. During the start-up delay only osc_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_hi_we_i | input | 1 | Write strobe for mode bits [2:1] |
| mode_hi_i | input | 2 | Data for mode bits [2:1] |
| mode_lo_we_i | input | 1 | Write strobe for mode bit [0] |
| mode_lo_i | input | 1 | Data for mode bit [0] |
| sleep_en_i | input | 1 | Sleep permitted |
| sleep_req_i | input | 1 | Sleep instruction strobe |
| xtal_src_i | input | 1 | External crystal or resonator configured |
| startup_sel_i | input | 2 | Start-up delay select |
| slow_tick_i | input | 1 | Sample strobe from the always-running slow clock |
| wake_src_i | input | 9 | Wake sources, bit map as in R6 |
| mode_o | output | 3 | Current mode field |
| cpu_en_o | output | 1 | CPU clock enable |
| flash_en_o | output | 1 | Flash clock enable |
| io_en_o | output | 1 | I/O and peripheral clock enable |
| tmr_en_o | output | 1 | Asynchronous timer clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| sleeping_o | output | 1 | Not in the active state |
| wake_o | output | 1 | One-cycle resume pulse |
| rst_req_o | output | 1 | One-cycle reset request on a reset-class wake |

## Verification
A bad latched mode shows up at once in the enable pattern sampled one cycle after sleep entry. It also shows up as a wake source accepted or refused against the mode's mask. A wrong filter count or start-up counter moves the resume cycle, which the bench measures to the exact cycle. It also lets an interrupted level request wake the block. A wrong cause flag swaps wake_o and rst_req_o on the resume cycle.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int WK_N = 9;
  localparam int WK_LVL0 = 3;
  localparam int WK_LVL1 = 4;
  localparam logic [WK_N-1:0] WK_RST_MASK = 9'b0_0000_0111;

  localparam logic [2:0] M_IDLE  = 3'b000;
  localparam logic [2:0] M_PDOWN = 3'b010;
  localparam logic [2:0] M_PSAVE = 3'b011;
  localparam logic [2:0] M_STBY  = 3'b110;
  localparam logic [2:0] M_XSTBY = 3'b111;

  typedef enum logic [1:0] {ST_ACTIVE, ST_SLEEP, ST_START} state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic tmr;
    logic osc;
  } clk_en_t;

  function automatic logic mode_valid(logic [2:0] m);
    return (m == M_IDLE) || (m == M_PDOWN) || (m == M_PSAVE) ||
           (m == M_STBY) || (m == M_XSTBY);
  endfunction

  function automatic logic osc_stops(logic [2:0] m);
    return (m == M_PDOWN) || (m == M_PSAVE);
  endfunction

  function automatic clk_en_t sleep_clk_set(logic [2:0] m);
    clk_en_t e;
    e = '0;
    case (m)
      M_IDLE:  begin e.io = 1'b1; e.tmr = 1'b1; e.osc = 1'b1; end
      M_PSAVE: e.tmr = 1'b1;
      M_STBY:  e.osc = 1'b1;
      M_XSTBY: begin e.tmr = 1'b1; e.osc = 1'b1; end
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [WK_N-1:0] wake_mask(logic [2:0] m);
    logic [WK_N-1:0] k;
    case (m)
      M_IDLE:           k = '1;
      M_PDOWN, M_STBY:  k = 9'b0_0111_1111;
      M_PSAVE, M_XSTBY: k = 9'b0_1111_1111;
      default:          k = '0;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/sleep_mode_reg.sv
module sleep_mode_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hi_we_i,
  input  logic [1:0] hi_i,
  input  logic       lo_we_i,
  input  logic       lo_i,
  output logic [2:0] mode_o
);
  logic [1:0] hi_q;
  logic       lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= 1'b0;
    end else begin
      if (hi_we_i) hi_q <= hi_i;
      if (lo_we_i) lo_q <= lo_i;
    end
  end

  assign mode_o = {hi_q, lo_q};
endmodule

// File: rtl/sleep_lvl_filter.sv
module sleep_lvl_filter #(
  parameter int NUM  = 2,
  parameter int HOLD = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic           tick_i,
  input  logic [NUM-1:0] lvl_i,
  output logic [NUM-1:0] ok_o
);
  localparam int CW = $clog2(HOLD + 1);

  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cnt_q <= '0;
      else if (!arm_i || !lvl_i[g])         cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(HOLD)) cnt_q <= cnt_q + 1'b1;
    end

    assign ok_o[g] = (cnt_q == CW'(HOLD));

    // R7
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(HOLD));
  end
endmodule

// File: rtl/sleep_startup_timer.sv
module sleep_startup_timer #(
  parameter int DLY_BASE = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  localparam int DLY_MAX = DLY_BASE << (2 * ((1 << SEL_W) - 1));
  localparam int CW      = $clog2(DLY_MAX + 1);

  logic [CW-1:0] cnt_q, dly;
  logic          run_q;

  assign dly = CW'(DLY_BASE) << {sel_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= dly - 1'b1;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  // R8
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> !done_o);
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_pkg::*;
#(
  parameter int LVL_HOLD = 3,
  parameter int DLY_BASE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_hi_we_i,
  input  logic [1:0]      mode_hi_i,
  input  logic            mode_lo_we_i,
  input  logic            mode_lo_i,
  input  logic            sleep_en_i,
  input  logic            sleep_req_i,
  input  logic            xtal_src_i,
  input  logic [1:0]      startup_sel_i,
  input  logic            slow_tick_i,
  input  logic [WK_N-1:0] wake_src_i,
  output logic [2:0]      mode_o,
  output logic            cpu_en_o,
  output logic            flash_en_o,
  output logic            io_en_o,
  output logic            tmr_en_o,
  output logic            osc_en_o,
  output logic            sleeping_o,
  output logic            wake_o,
  output logic            rst_req_o
);
  state_e          state_q, state_d;
  logic [2:0]      mode, cur_q;
  logic [1:0]      lvl_ok;
  logic [WK_N-1:0] eff_src, hit;
  logic            start_done, enter_ok, rst_cause_q, rst_cause_d;
  clk_en_t         en_q, en_d;
  logic            wake_d, rreq_d, wake_q, rreq_q;

  sleep_mode_reg u_mode (
    .clk_i, .rst_ni,
    .hi_we_i(mode_hi_we_i), .hi_i(mode_hi_i),
    .lo_we_i(mode_lo_we_i), .lo_i(mode_lo_i),
    .mode_o (mode)
  );

  sleep_lvl_filter #(.NUM(2), .HOLD(LVL_HOLD)) u_lvl (
    .clk_i, .rst_ni,
    .arm_i (state_q == ST_SLEEP),
    .tick_i(slow_tick_i),
    .lvl_i ({wake_src_i[WK_LVL1], wake_src_i[WK_LVL0]}),
    .ok_o  (lvl_ok)
  );

  sleep_startup_timer #(.DLY_BASE(DLY_BASE), .SEL_W(2)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(state_q == ST_SLEEP && state_d == ST_START),
    .sel_i (startup_sel_i),
    .done_o(start_done)
  );

  // Idle takes raw levels; deeper modes take filtered ones
  always_comb begin
    eff_src = wake_src_i;
    if (cur_q != M_IDLE) begin
      eff_src[WK_LVL0] = lvl_ok[0];
      eff_src[WK_LVL1] = lvl_ok[1];
    end
    hit = eff_src & wake_mask(cur_q);
  end

  assign enter_ok = sleep_req_i && sleep_en_i && mode_valid(mode) &&
                    (!mode[2] || xtal_src_i);

  always_comb begin
    state_d     = state_q;
    rst_cause_d = rst_cause_q;
    case (state_q)
      ST_ACTIVE: if (enter_ok) state_d = ST_SLEEP;
      ST_SLEEP: if (|hit) begin
        state_d     = osc_stops(cur_q) ? ST_START : ST_ACTIVE;
        rst_cause_d = |(hit & WK_RST_MASK);
      end
      ST_START: if (start_done) state_d = ST_ACTIVE;
      default:  state_d = ST_ACTIVE;
    endcase
  end

  // Enables come from the next state so they move on one edge only
  always_comb begin
    case (state_d)
      ST_SLEEP: en_d = sleep_clk_set(state_q == ST_ACTIVE ? mode : cur_q);
      ST_START: en_d = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, tmr: 1'b0, osc: 1'b1};
      default:  en_d = '1;
    endcase
    wake_d = (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE) && !rst_cause_d;
    rreq_d = (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE) &&  rst_cause_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ACTIVE;
      cur_q       <= M_IDLE;
      rst_cause_q <= 1'b0;
      en_q        <= '1;
      wake_q      <= 1'b0;
      rreq_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_cause_q <= rst_cause_d;
      en_q        <= en_d;
      wake_q      <= wake_d;
      rreq_q      <= rreq_d;
      if (state_q == ST_ACTIVE && enter_ok) cur_q <= mode;
    end
  end

  assign mode_o     = mode;
  assign cpu_en_o   = en_q.cpu;
  assign flash_en_o = en_q.flash;
  assign io_en_o    = en_q.io;
  assign tmr_en_o   = en_q.tmr;
  assign osc_en_o   = en_q.osc;
  assign sleeping_o = (state_q != ST_ACTIVE);
  assign wake_o     = wake_q;
  assign rst_req_o  = rreq_q;

  // R3
  reserved_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACTIVE && !mode_valid(mode) |=> state_q == ST_ACTIVE);
  // R5
  cpu_off_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SLEEP |-> !cpu_en_o && !flash_en_o);
  // R9
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o || rst_req_o |=> !wake_o && !rst_req_o);
  // R9
  cause_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_o && rst_req_o));
  // R10
  start_osc_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_START |-> osc_en_o && !cpu_en_o && !io_en_o && !tmr_en_o);
  // R10
  en_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q != $past(en_q) |-> state_q != $past(state_q));
endmodule

// File: tb/sleep_clk_ctrl_tb_top.sv
module sleep_clk_ctrl_tb_top;
  localparam int N_HOLD = 3;
  localparam int D_BASE = 4;
  localparam int LIM    = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi_we = 0, lo_we = 0, lo_d = 0;
  logic [1:0] hi_d = '0;
  logic       sl_en = 0, sl_req = 0, xtal = 0, tick = 0;
  logic [1:0] ssel = '0;
  logic [8:0] src = '0;
  logic [2:0] mode;
  logic       cpu_en, flash_en, io_en, tmr_en, osc_en, sleeping, wake, rreq;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sleep_clk_ctrl #(.LVL_HOLD(N_HOLD), .DLY_BASE(D_BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_hi_we_i(hi_we), .mode_hi_i(hi_d), .mode_lo_we_i(lo_we), .mode_lo_i(lo_d),
    .sleep_en_i(sl_en), .sleep_req_i(sl_req), .xtal_src_i(xtal),
    .startup_sel_i(ssel), .slow_tick_i(tick), .wake_src_i(src),
    .mode_o(mode), .cpu_en_o(cpu_en), .flash_en_o(flash_en), .io_en_o(io_en),
    .tmr_en_o(tmr_en), .osc_en_o(osc_en), .sleeping_o(sleeping),
    .wake_o(wake), .rst_req_o(rreq)
  );

  wire [4:0] en_v = {cpu_en, flash_en, io_en, tmr_en, osc_en};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit valid_m(input int m);
    return m == 0 || m == 2 || m == 3 || m == 6 || m == 7;
  endfunction

  function automatic int exp_en(input int m);
    case (m)
      0: return 5'b00111;
      2: return 5'b00000;
      3: return 5'b00010;
      6: return 5'b00001;
      7: return 5'b00011;
      default: return 5'b11111;
    endcase
  endfunction

  function automatic bit exp_acc(input int m, input int b);
    if (m == 0) return 1;
    if (b <= 6) return 1;
    if (b == 7) return m == 3 || m == 7;
    return 0;
  endfunction

  function automatic int exp_dly(input int m, input int sel);
    return (m == 2 || m == 3) ? (D_BASE << (2 * sel)) : 0;
  endfunction

  task automatic set_mode(input int m);
    @(negedge clk);
    hi_we = 1; lo_we = 1; hi_d = 2'(m >> 1); lo_d = m[0];
    @(negedge clk);
    hi_we = 0; lo_we = 0;
  endtask

  task automatic strobe();
    @(negedge clk); sl_req = 1;
    @(negedge clk); sl_req = 0;
  endtask

  // apply source b, count negedges until a resume pulse
  task automatic wake_by(input int b, output int n, output bit was_rst);
    @(negedge clk);
    src[b] = 1'b1;
    n = -1; was_rst = 0;
    for (int i = 1; i <= LIM + 300; i++) begin
      @(negedge clk);
      if (wake || rreq) begin n = i; was_rst = rreq; break; end
      if (i == LIM && b != 6 && !exp_acc(int'(dut_mode_s), b)) break;
    end
    src[b] = 1'b0;
  endtask

  logic [2:0] dut_mode_s;

  task automatic exit_sleep();
    int n; bit r;
    wake_by(6, n, r);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int n; bit r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(mode == 0, "R1 mode", mode, 0);
    chk(en_v == 5'b11111, "R1 enables", en_v, 31);
    chk(!sleeping && !wake && !rreq, "R1 status", {sleeping, wake, rreq}, 0);

    // R2 split writes
    @(negedge clk); hi_we = 1; hi_d = 2'b11; @(negedge clk); hi_we = 0;
    chk(mode == 3'b110, "R2 hi write", mode, 6);
    lo_we = 1; lo_d = 1; @(negedge clk); lo_we = 0;
    chk(mode == 3'b111, "R2 lo write", mode, 7);
    hi_we = 1; hi_d = 2'b00; @(negedge clk); hi_we = 0;
    chk(mode == 3'b001, "R2 hi keeps lo", mode, 1);

    // R3 sleep enable low
    tick = 1;
    set_mode(2);
    sl_en = 0; strobe();
    chk(!sleeping && en_v == 5'b11111, "R3 sleep_en low", sleeping, 0);
    sl_en = 1;

    // R3 R4 R5 entry sweep
    for (int m = 0; m < 8; m++) begin
      for (int x = 0; x < 2; x++) begin
        bit ent;
        set_mode(m); xtal = x[0]; dut_mode_s = 3'(m);
        strobe();
        ent = valid_m(m) && (m < 4 || x == 1);
        if (m >= 6) chk(sleeping == ent, "R4 xtal gate", sleeping, ent);
        else        chk(sleeping == ent, "R3 entry", sleeping, ent);
        if (ent) begin
          chk(en_v == exp_en(m), "R5 enable set", en_v, exp_en(m));
          exit_sleep();
          chk(en_v == 5'b11111, "R5 active enables", en_v, 31);
        end else begin
          chk(en_v == 5'b11111, "R3 ignored enables", en_v, 31);
        end
      end
    end

    // R6 R7 R8 R9 wake source sweep
    xtal = 1; ssel = 0;
    for (int m = 0; m < 8; m++) begin
      if (!valid_m(m)) continue;
      for (int b = 0; b < 9; b++) begin
        int e;
        set_mode(m); dut_mode_s = 3'(m);
        strobe();
        wake_by(b, n, r);
        if (exp_acc(m, b)) begin
          e = ((b == 3 || b == 4) && m != 0 ? N_HOLD + 1 : 1) + exp_dly(m, 0);
          if (b == 3 || b == 4) chk(n == e, "R7 level wake cycle", n, e);
          else                  chk(n == e, "R6 wake cycle", n, e);
          chk(r == (b <= 2), "R9 cause", r, b <= 2);
          @(negedge clk);
          chk(!wake && !rreq, "R9 one cycle", wake | rreq, 0);
        end else begin
          chk(n == -1 && sleeping, "R6 masked source", n, -1);
          exit_sleep();
        end
      end
    end

    // R8 R10 delay select sweep in power-down
    for (int s = 0; s < 4; s++) begin
      int e;
      ssel = 2'(s);
      set_mode(2); dut_mode_s = 3'd2;
      strobe();
      @(negedge clk); src[6] = 1;
      @(negedge clk); src[6] = 0;
      chk(en_v == 5'b00001 && sleeping, "R10 start osc only", en_v, 1);
      n = 1;
      while (!wake && n < 400) begin @(negedge clk); n++; end
      e = 1 + (D_BASE << (2 * s));
      chk(n == e, "R8 startup delay", n, e);
      chk(en_v == 5'b11111, "R10 resume enables", en_v, 31);
    end

    // R7 interrupted level does not wake; standby has no delay
    ssel = 0;
    set_mode(6); dut_mode_s = 3'd6;
    strobe();
    @(negedge clk); src[3] = 1;
    repeat (N_HOLD - 1) @(negedge clk);
    src[3] = 0;
    repeat (20) @(negedge clk);
    chk(sleeping && !wake, "R7 short level ignored", sleeping, 1);
    @(negedge clk); src[4] = 1; tick = 0;
    repeat (10) @(negedge clk);
    chk(sleeping, "R7 no tick no count", sleeping, 1);
    tick = 1;
    n = 0;
    while (!wake && n < 50) begin @(negedge clk); n++; end
    src[4] = 0;
    chk(n == N_HOLD + 1, "R7 R8 standby level resume", n, N_HOLD + 1);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule